// File: doc/BRIEF.md
# Staged Card Reset Sequencer

This block brings a multi-processor card out of reset in a fixed, timed order. It watches a host-side power-good signal and a set of local rail-good signals. Both inputs are asynchronous, so each passes through a two-flop synchroniser. Once the host reports power-good and every rail is good, the block releases the peripheral resets together: the PCIe switch, the Ethernet PHY, the serial fabric switch and the per-processor reset lines. A fixed long delay later it releases the processors' power-on reset. After a second long delay it releases their full reset.

From the power-on release onward, the block drives a captured boot-strap word onto the shared configuration pins. The processors therefore latch a stable value when the full reset rises. A short hold window after that release, the block turns the pin output enables off and flags the sequence as done.

All delays are whole clock cycles, derived from a clock-frequency parameter. A divisor parameter shortens them for fast simulation. If power-good or any rail drops at any time, the block returns to its idle state and asserts every reset again.

Top module: `rst_sequencer`

## Requirements
- R1: While `rstN` is low, and right after it rises, every reset output is 0 (all resets are active-low), `strapOe` is 0, `seqDone` is 0 and `seqState` is 0.
- R2: The sequence does not start while `hostPwrOk` is low or any bit of `railGood` is low. `seqState` stays 0 and every reset stays low.
- R3: The first release step sets `pcieSwRstN`, `phyRstN`, `fabricRstN` and every bit of `procRstN` high in the same cycle. `procPorN` and `procFullRstN` stay low in that cycle.
- R4: `procPorN` rises exactly LONG_CYC cycles after the first release step, where LONG_CYC = 5·(CLK_HZ/1000)/SIM_DIV.
- R5: `procFullRstN` rises exactly LONG_CYC cycles after `procPorN` rises.
- R6: `strapOe` goes high when `procPorN` rises. At that edge `strapOut` takes the value of `strapVal`, and it holds that value until `strapOe` falls, even if `strapVal` changes.
- R7: Exactly SHORT_CYC = (CLK_HZ/1000)/SIM_DIV cycles after `procFullRstN` rises, `strapOe` falls and `seqDone` rises. `seqDone` is high only in the final state.
- R8: If either input condition is lost, three clock edges later `seqState` is 0, every reset output is low and `strapOe` and `seqDone` are 0. The sequence restarts from the beginning when both conditions hold again.
- R9: `seqState` encodes the phases as follows: 0 idle, 1 peripherals released, 2 power-on reset released, 3 full reset released, 4 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| hostPwrOk | input | 1 | Host power-good, asynchronous, high = good |
| railGood | input | N_RAIL | Local rail-good flags, asynchronous, high = good |
| strapVal | input | STRAP_W | Boot-strap word, captured when the power-on reset is released |
| pcieSwRstN | output | 1 | PCIe switch reset, active-low |
| phyRstN | output | 1 | Ethernet PHY reset, active-low |
| fabricRstN | output | 1 | Serial fabric switch reset, active-low |
| procRstN | output | N_PROC | Per-processor reset lines, active-low |
| procPorN | output | 1 | Processor power-on reset, active-low |
| procFullRstN | output | 1 | Processor full reset, active-low |
| strapOut | output | STRAP_W | Driven strap value |
| strapOe | output | 1 | Output enable for the strap pins |
| seqDone | output | 1 | Sequence complete |
| seqState | output | 3 | Current phase code |

## Verification
The loss-detection property assumes a lost input condition is held for at least three consecutive clock edges, so it is not filtered away by the synchronisers. The stimulus changes power inputs only at falling edges, and it holds each level for at least three cycles. The strap-stability property assumes nothing about `strapVal`. The stimulus changes `strapVal` in the middle of the strap window on purpose, so that the capture is tested.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PERIPH = 3'd1,
    ST_POR    = 3'd2,
    ST_FULL   = 3'd3,
    ST_DONE   = 3'd4
  } seqPhase_t;

  typedef struct packed {
    logic clrAll;
    logic relPeriph;
    logic relPor;
    logic relFull;
    logic relStrap;
    logic loadLong;
    logic loadShort;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerOk,
  input  logic       timerDone,
  output seqStrobe_t stb,
  output seqPhase_t  phase
);

  seqPhase_t nextPhase;

  always_comb begin
    stb       = '0;
    nextPhase = phase;
    if (!powerOk) begin
      nextPhase  = ST_IDLE;
      stb.clrAll = 1'b1;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          nextPhase     = ST_PERIPH;
          stb.relPeriph = 1'b1;
          stb.loadLong  = 1'b1;
        end
        ST_PERIPH: if (timerDone) begin
          nextPhase    = ST_POR;
          stb.relPor   = 1'b1;
          stb.loadLong = 1'b1;
        end
        ST_POR: if (timerDone) begin
          nextPhase     = ST_FULL;
          stb.relFull   = 1'b1;
          stb.loadShort = 1'b1;
        end
        ST_FULL: if (timerDone) begin
          nextPhase    = ST_DONE;
          stb.relStrap = 1'b1;
        end
        ST_DONE: nextPhase = ST_DONE;
        default: begin
          nextPhase  = ST_IDLE;
          stb.clrAll = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= nextPhase;
  end

endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int LONG_CYC  = 50,
  parameter int SHORT_CYC = 10,
  parameter int STRAP_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [STRAP_W-1:0] strapVal,
  output logic               timerDone,
  output logic               periphRel,
  output logic               porRel,
  output logic               fullRel,
  output logic               oeOn,
  output logic               doneFlag,
  output logic [STRAP_W-1:0] strapHeld
);

  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_CYC - 1);
  localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (stb.clrAll)     cnt <= '0;
    else if (stb.loadLong)   cnt <= LONG_LOAD;
    else if (stb.loadShort)  cnt <= SHORT_LOAD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign timerDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periphRel <= 1'b0;
      porRel    <= 1'b0;
      fullRel   <= 1'b0;
      oeOn      <= 1'b0;
      doneFlag  <= 1'b0;
      strapHeld <= '0;
    end else if (stb.clrAll) begin
      periphRel <= 1'b0;
      porRel    <= 1'b0;
      fullRel   <= 1'b0;
      oeOn      <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      if (stb.relPeriph) periphRel <= 1'b1;
      if (stb.relPor) begin
        porRel    <= 1'b1;
        oeOn      <= 1'b1;
        strapHeld <= strapVal;
      end
      if (stb.relFull) fullRel <= 1'b1;
      if (stb.relStrap) begin
        oeOn     <= 1'b0;
        doneFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int SIM_DIV = 1,
  parameter int N_RAIL  = 4,
  parameter int N_PROC  = 8,
  parameter int STRAP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostPwrOk,
  input  logic [N_RAIL-1:0]  railGood,
  input  logic [STRAP_W-1:0] strapVal,
  output logic               pcieSwRstN,
  output logic               phyRstN,
  output logic               fabricRstN,
  output logic [N_PROC-1:0]  procRstN,
  output logic               procPorN,
  output logic               procFullRstN,
  output logic [STRAP_W-1:0] strapOut,
  output logic               strapOe,
  output logic               seqDone,
  output logic [2:0]         seqState
);

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int LONG_RAW   = (5 * CYC_PER_MS) / SIM_DIV;
  localparam int SHORT_RAW  = CYC_PER_MS / SIM_DIV;
  localparam int LONG_CYC   = (LONG_RAW  < 1) ? 1 : LONG_RAW;
  localparam int SHORT_CYC  = (SHORT_RAW < 1) ? 1 : SHORT_RAW;

  logic [N_RAIL:0] syncBits;
  logic            powerOk;
  logic            timerDone;
  logic            periphRel;
  logic            porRel;
  logic            fullRel;
  seqStrobe_t      stb;
  seqPhase_t       phase;

  rst_seq_sync #(.WIDTH(N_RAIL + 1)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({hostPwrOk, railGood}),
    .syncOut (syncBits)
  );

  assign powerOk = syncBits[N_RAIL] & (&syncBits[N_RAIL-1:0]);

  rst_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerOk   (powerOk),
    .timerDone (timerDone),
    .stb       (stb),
    .phase     (phase)
  );

  rst_seq_dp #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC),
    .STRAP_W   (STRAP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .strapVal  (strapVal),
    .timerDone (timerDone),
    .periphRel (periphRel),
    .porRel    (porRel),
    .fullRel   (fullRel),
    .oeOn      (strapOe),
    .doneFlag  (seqDone),
    .strapHeld (strapOut)
  );

  assign pcieSwRstN   = periphRel;
  assign phyRstN      = periphRel;
  assign fabricRstN   = periphRel;
  assign procPorN     = porRel;
  assign procFullRstN = fullRel;
  assign seqState     = phase;

  for (genvar p = 0; p < N_PROC; p++) begin : g_proc
    assign procRstN[p] = periphRel;
  end

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int N_RAIL  = 4,
  parameter int N_PROC  = 8,
  parameter int STRAP_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostPwrOk,
  input logic [N_RAIL-1:0]  railGood,
  input logic               pcieSwRstN,
  input logic [N_PROC-1:0]  procRstN,
  input logic               procPorN,
  input logic               procFullRstN,
  input logic [STRAP_W-1:0] strapOut,
  input logic               strapOe,
  input logic               seqDone,
  input logic [2:0]         seqState
);

  logic powerLost;
  assign powerLost = !hostPwrOk || !(&railGood);

  AST_RESET_CLEAN: assert property (@(posedge clk) !rstN |-> (!pcieSwRstN && !procPorN && !strapOe && !seqDone)); // R1
  AST_PROC_UNIFORM: assert property (@(posedge clk) disable iff (!rstN) ($countones(procRstN) == 0 || $countones(procRstN) == N_PROC)); // R3
  AST_POR_AFTER_PERIPH: assert property (@(posedge clk) disable iff (!rstN) !pcieSwRstN |-> !procPorN); // R4
  AST_FULL_AFTER_POR: assert property (@(posedge clk) disable iff (!rstN) !procPorN |-> !procFullRstN); // R5
  AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!rstN) (strapOe && $past(strapOe)) |-> $stable(strapOut)); // R6
  AST_OE_WITH_POR: assert property (@(posedge clk) disable iff (!rstN) strapOe |-> (procPorN && !seqDone)); // R6
  AST_DONE_FINAL: assert property (@(posedge clk) disable iff (!rstN) seqDone |-> (seqState == 3'd4 && procFullRstN)); // R7
  AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (powerLost && $past(powerLost) && $past(powerLost, 2)) |=> (!pcieSwRstN && !strapOe && !seqDone && seqState == 3'd0)); // R8
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rstN) seqState <= 3'd4); // R9

endmodule

bind rst_sequencer rst_sequencer_chk #(
  .N_RAIL  (N_RAIL),
  .N_PROC  (N_PROC),
  .STRAP_W (STRAP_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostPwrOk    (hostPwrOk),
  .railGood     (railGood),
  .pcieSwRstN   (pcieSwRstN),
  .procRstN     (procRstN),
  .procPorN     (procPorN),
  .procFullRstN (procFullRstN),
  .strapOut     (strapOut),
  .strapOe      (strapOe),
  .seqDone      (seqDone),
  .seqState     (seqState)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int SIM_DIV    = 100;
  localparam int N_RAIL     = 4;
  localparam int N_PROC     = 8;
  localparam int STRAP_W    = 16;
  localparam int SHORT_EXP  = (CLK_HZ / 1000) / SIM_DIV;
  localparam int LONG_EXP   = 5 * SHORT_EXP;

  typedef struct {
    int          st;
    int          gap;
    logic [15:0] strap;
  } expItem_t;

  logic               clk = 1'b0;
  logic               rstN;
  logic               hostPwrOk;
  logic [N_RAIL-1:0]  railGood;
  logic [STRAP_W-1:0] strapVal;
  logic               pcieSwRstN, phyRstN, fabricRstN;
  logic [N_PROC-1:0]  procRstN;
  logic               procPorN, procFullRstN;
  logic [STRAP_W-1:0] strapOut;
  logic               strapOe, seqDone;
  logic [2:0]         seqState;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int lastCyc = 0;
  int prevSt  = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rst_sequencer #(
    .CLK_HZ  (CLK_HZ),
    .SIM_DIV (SIM_DIV),
    .N_RAIL  (N_RAIL),
    .N_PROC  (N_PROC),
    .STRAP_W (STRAP_W)
  ) u_rst_sequencer (
    .clk          (clk),
    .rstN         (rstN),
    .hostPwrOk    (hostPwrOk),
    .railGood     (railGood),
    .strapVal     (strapVal),
    .pcieSwRstN   (pcieSwRstN),
    .phyRstN      (phyRstN),
    .fabricRstN   (fabricRstN),
    .procRstN     (procRstN),
    .procPorN     (procPorN),
    .procFullRstN (procFullRstN),
    .strapOut     (strapOut),
    .strapOe      (strapOe),
    .seqDone      (seqDone),
    .seqState     (seqState)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  task automatic checkIdle(input string req);
    chk(req, {29'd0, seqState}, 32'd0);
    chk(req, {pcieSwRstN, phyRstN, fabricRstN, procPorN, procFullRstN, strapOe, seqDone}, 32'd0);
    chk(req, {24'd0, procRstN}, 32'd0);
  endtask

  task automatic pushSeq(input logic [15:0] sv);
    expQ.push_back('{st: 1, gap: 0,         strap: sv});
    expQ.push_back('{st: 2, gap: LONG_EXP,  strap: sv});
    expQ.push_back('{st: 3, gap: LONG_EXP,  strap: sv});
    expQ.push_back('{st: 4, gap: SHORT_EXP, strap: sv});
  endtask

  task automatic waitState(input int s);
    int n = 0;
    while (int'(seqState) != s && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Monitor: pops the expected phase on every phase change and checks the outputs
  always @(negedge clk) begin
    cyc++;
    if (rstN && int'(seqState) != prevSt) begin
      if (expQ.size() == 0) begin
        misses++;
        $display("FAIL R9: got unexpected phase %0d expected none", seqState);
      end else begin
        expItem_t e;
        int st;
        e  = expQ.pop_front();
        st = int'(seqState);
        chk("R9 phase order", st, e.st);
        if (e.gap != 0) chk("R4/R5/R7 gap", cyc - lastCyc, e.gap);
        chk("R3 periph", {pcieSwRstN, phyRstN, fabricRstN}, (st >= 1) ? 3'b111 : 3'b000);
        chk("R3 procRst", {24'd0, procRstN}, (st >= 1) ? {24'd0, {N_PROC{1'b1}}} : 32'd0);
        chk("R4 por", procPorN, st >= 2);
        chk("R5 full", procFullRstN, st >= 3);
        chk("R6 oe", strapOe, (st == 2 || st == 3));
        chk("R7 done", seqDone, st == 4);
        if (st == 2 || st == 3) chk("R6 strap", strapOut, e.strap);
      end
      lastCyc = cyc;
      prevSt  = int'(seqState);
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected finish");
    report();
  end

  initial begin
    rstN      = 1'b0;
    hostPwrOk = 1'b0;
    railGood  = '0;
    strapVal  = 16'hA5C3;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // R2: one rail missing, then host missing
    hostPwrOk = 1'b1;
    railGood  = 4'b1011;
    repeat (40) @(negedge clk);
    checkIdle("R2 rail low");
    hostPwrOk = 1'b0;
    railGood  = 4'hF;
    repeat (40) @(negedge clk);
    checkIdle("R2 host low");

    // Full sequence, strap input changed mid-window
    pushSeq(16'hA5C3);
    hostPwrOk = 1'b1;
    waitState(2);
    strapVal = 16'h0F0F;
    repeat (5) @(negedge clk);
    chk("R6 held after change", {strapOe, strapOut}, {1'b1, 16'hA5C3});
    waitState(4);
    repeat (5) @(negedge clk);
    chk("R7 done held", {seqDone, strapOe}, 2'b10);

    // R8: rail drop in the final state
    expQ.push_back('{st: 0, gap: 0, strap: 16'h0});
    railGood[2] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 not yet", {29'd0, seqState}, 32'd4);
    @(negedge clk);
    checkIdle("R8 rail drop");

    // Restart, then host drop inside the strap window
    strapVal = 16'h3C96;
    expQ.push_back('{st: 1, gap: 0,        strap: 16'h3C96});
    expQ.push_back('{st: 2, gap: LONG_EXP, strap: 16'h3C96});
    railGood = 4'hF;
    waitState(2);
    repeat (10) @(negedge clk);
    expQ.push_back('{st: 0, gap: 0, strap: 16'h0});
    hostPwrOk = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R8 host drop");

    // Clean rerun to completion
    pushSeq(16'h3C96);
    hostPwrOk = 1'b1;
    waitState(4);
    repeat (5) @(negedge clk);
    chk("R7 final done", seqDone, 1'b1);
    chk("R9 all phases seen", expQ.size(), 0);
    report();
  end

endmodule